// File: doc/BRIEF.md
# Two-Wire Master SCL Waveform Generator

This block derives the serial clock of a two-wire bus master from the system clock. One configuration word carries a divider for the low level, a divider for the high level and a power-of-two prescale exponent that both dividers share. Each SCL phase lasts the divider shifted left by the exponent, plus a fixed build-time offset, in system clock cycles. Two common settings for that offset are 3 and 4.

The bit engine that sits beside the block receives the divided SCL level and two one-cycle strobes, one at the start of each low phase and one at the start of each high phase. It can hold the generator in the low phase to stretch the bus clock. A configuration written mid-period is picked up only when the next low phase begins, so a phase in progress is never cut short. While the engine is disabled, SCL rests high and the phase counter is cleared.

An exponent above the build-time maximum is clamped to that maximum, and both dividers are then forced to their largest value. This gives the slowest clock the block can produce.

Top module: `scl_wavegen`

## Requirements
- R1: During and after reset, with the engine disabled, `scl_o` is 1, both strobes are 0 and `cfg_rdata_o` reads 0.
- R2: The configuration word holds the low divider in bits [7:0], the high divider in bits [15:8] and the exponent in bits [18:16]. Bits [31:19] are not stored and read back as 0.
- R3: A write whose exponent field exceeds `CKDIV_MAX` stores the exponent `CKDIV_MAX` and sets both dividers to 255. A write whose exponent equals `CKDIV_MAX` is stored unchanged.
- R4: Each low phase lasts exactly (low divider × 2^exponent + `OFFSET`) system clock cycles, counted from `low_start_o` up to, but not including, `high_start_o`.
- R5: Each high phase lasts exactly (high divider × 2^exponent + `OFFSET`) cycles, counted from `high_start_o` up to, but not including, the next `low_start_o`.
- R6: `low_start_o` is 1 only in the first cycle of a low phase, and `high_start_o` is 1 only in the first cycle of a high phase. The two strobes are never 1 together. `scl_o` is 0 exactly while a low phase is running.
- R7: A configuration written during a period does not change that period's low or high length. It applies from the next low phase onward.
- R8: Each cycle in which `stretch_i` is 1 during a low phase freezes the counter, so SCL stays low and the low phase grows by one cycle. `stretch_i` has no effect during a high phase.
- R9: While `enable_i` is 0, `scl_o` is 1 and both strobes are 0 from the next cycle on. The cycle after `enable_i` is first sampled as 1, a low phase starts, with `low_start_o` set to 1 and `scl_o` set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | Engine enable. When 0, SCL idles high and the counter is cleared |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Stored configuration, after clamping |
| stretch_i | input | 1 | Holds the low phase while 1 |
| scl_o | output | 1 | Divided SCL level |
| low_start_o | output | 1 | One-cycle strobe at the start of each low phase |
| high_start_o | output | 1 | One-cycle strobe at the start of each high phase |

## Verification
The assertions assume that `enable_i`, `stretch_i` and the write port are synchronous to the system clock. They also assume that a write may carry any 32-bit value, including an out-of-range exponent and set upper bits, because the clamp and the field decode must absorb such values. The bench changes every input on the falling edge and samples on the falling edge, so each input is stable across the rising edge that captures it. Stretch is raised both in the low phase, where it must extend the phase, and in the high phase, where it must change nothing. The sweep covers every exponent up to the maximum of a small build, together with all small divider values, and it also writes values that exercise the clamp.

// File: rtl/scl_wg_pkg.sv
package scl_wg_pkg;
  parameter int DIV_W = 8;
  parameter int CK_W  = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Packed order places lo at [7:0], hi at [15:8], ck at [18:16]
  typedef struct packed {
    logic [CK_W-1:0]  ck;
    logic [DIV_W-1:0] hi;
    logic [DIV_W-1:0] lo;
  } wave_cfg_t;
endpackage

// File: rtl/scl_wg_cfg_reg.sv
module scl_wg_cfg_reg
  import scl_wg_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int CKDIV_MAX = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output wave_cfg_t        cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int FIELD_W = $bits(wave_cfg_t);

  wave_cfg_t wr_cfg;
  wave_cfg_t cfg_d;
  wave_cfg_t cfg_q;
  logic      unused_hi;

  assign wr_cfg    = wave_cfg_t'(wdata_i[FIELD_W-1:0]);
  assign unused_hi = ^wdata_i[REG_W-1:FIELD_W];

  // Field decode with exponent clamp
  always_comb begin
    cfg_d = wr_cfg;
    if (int'(wr_cfg.ck) > CKDIV_MAX) begin
      cfg_d.ck = CK_W'(CKDIV_MAX);
      cfg_d.lo = '1;
      cfg_d.hi = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(REG_W-FIELD_W){1'b0}}, cfg_q};

  AST_CK_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cfg_q.ck) <= CKDIV_MAX);  // R3

  AST_CLAMP_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(wdata_i[2*DIV_W +: CK_W]) > CKDIV_MAX) |=>
      (cfg_q.lo == '1 && cfg_q.hi == '1 && int'(cfg_q.ck) == CKDIV_MAX));  // R3
endmodule

// File: rtl/scl_wg_len.sv
module scl_wg_len
  import scl_wg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int OFFSET = 4
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [CK_W-1:0]  ck_i,
  output logic [CNT_W-1:0] len_o
);
  assign len_o = (CNT_W'(div_i) << ck_i) + CNT_W'(OFFSET);
endmodule

// File: rtl/scl_wg_seq.sv
module scl_wg_seq
  import scl_wg_pkg::*;
#(
  parameter int OFFSET    = 4,
  parameter int CKDIV_MAX = 7
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  logic      stretch_i,
  input  wave_cfg_t cfg_i,
  output logic      scl_o,
  output logic      low_start_o,
  output logic      high_start_o
);
  localparam int MAX_LEN = ((2**DIV_W) - 1) * (2**CKDIV_MAX) + OFFSET;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int N_PH    = 2;

  phase_e           phase_d, phase_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  wave_cfg_t        act_q;
  logic             act_load;
  logic             ls_d, ls_q, hs_d, hs_q;
  logic [CNT_W-1:0] len_w [N_PH];

  // Index 0 is the low phase, index 1 the high phase
  for (genvar g = 0; g < N_PH; g++) begin : g_len
    scl_wg_len #(
      .CNT_W  (CNT_W),
      .OFFSET (OFFSET)
    ) u_len (
      .div_i (g == 0 ? act_q.lo : act_q.hi),
      .ck_i  (act_q.ck),
      .len_o (len_w[g])
    );
  end

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    act_load = 1'b0;
    if (!enable_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_LOW;
          cnt_d    = '0;
          act_load = 1'b1;
        end
        PH_LOW: begin
          if (!stretch_i) begin
            if (cnt_q == len_w[0] - 1'b1) begin
              phase_d = PH_HIGH;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_HIGH: begin
          if (cnt_q == len_w[1] - 1'b1) begin
            phase_d  = PH_LOW;
            cnt_d    = '0;
            act_load = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
    ls_d = (phase_d == PH_LOW)  && (phase_q != PH_LOW);
    hs_d = (phase_d == PH_HIGH) && (phase_q != PH_HIGH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ls_q    <= 1'b0;
      hs_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ls_q    <= ls_d;
      hs_q    <= hs_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (act_load) begin
      act_q <= cfg_i;
    end
  end

  assign scl_o        = (phase_q != PH_LOW);
  assign low_start_o  = ls_q;
  assign high_start_o = hs_q;

  AST_IDLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (scl_o && !low_start_o && !high_start_o));  // R9

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(low_start_o && high_start_o));  // R6

  AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && stretch_i && phase_q == PH_LOW) |=> (!scl_o && $stable(cnt_q)));  // R8

  AST_CFG_AT_LOW_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_start_o |-> $stable(act_q));  // R7
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wg_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int OFFSET    = 4,
  parameter int CKDIV_MAX = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             stretch_i,
  output logic             scl_o,
  output logic             low_start_o,
  output logic             high_start_o
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  wave_cfg_t  cfg_w;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  scl_wg_cfg_reg #(
    .REG_W     (REG_W),
    .CKDIV_MAX (CKDIV_MAX)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_s_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_w),
    .rdata_o (cfg_rdata_o)
  );

  scl_wg_seq #(
    .OFFSET    (OFFSET),
    .CKDIV_MAX (CKDIV_MAX)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_s_n),
    .enable_i     (enable_i),
    .stretch_i    (stretch_i),
    .cfg_i        (cfg_w),
    .scl_o        (scl_o),
    .low_start_o  (low_start_o),
    .high_start_o (high_start_o)
  );
endmodule

// File: tb/test_scl_wavegen.sv
module test_scl_wavegen;
  localparam int CLK_PERIOD = 10;
  localparam int OFS        = 3;
  localparam int CKM        = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        we;
  logic [31:0] wd;
  logic [31:0] rd;
  logic        stretch;
  logic        scl, ls, hs;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_wavegen #(
    .REG_W     (32),
    .OFFSET    (OFS),
    .CKDIV_MAX (CKM)
  ) i_scl_wavegen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .enable_i     (enable),
    .cfg_we_i     (we),
    .cfg_wdata_i  (wd),
    .cfg_rdata_o  (rd),
    .stretch_i    (stretch),
    .scl_o        (scl),
    .low_start_o  (ls),
    .high_start_o (hs)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int plen(input int d, input int c);
    return d * (1 << c) + OFS;
  endfunction

  function automatic logic [31:0] word(input int ck, input int hi, input int lo);
    return (32'(ck) << 16) | (32'(hi) << 8) | 32'(lo);
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    we = 1'b1;
    wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // Measures one full period; s = stretch cycles in low, stretch also held in high when s>0
  task automatic measure(input int s, input bit mid_wr, input logic [31:0] mid_d,
                         output int lo, output int hi);
    @(negedge clk);
    while (!ls) @(negedge clk);
    lo = 0;
    while (!hs) begin
      stretch = (lo < s);
      if (mid_wr) we = (lo == 0);
      if (lo == 0) wd = mid_d;
      lo++;
      @(negedge clk);
    end
    we      = 1'b0;
    stretch = (s > 0);
    hi = 0;
    do begin
      hi++;
      @(negedge clk);
    end while (!ls);
    stretch = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int lo_m, hi_m;
    rst_n   = 1'b0;
    enable  = 1'b0;
    we      = 1'b0;
    wd      = '0;
    stretch = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl in reset", int'(scl), 1);
    chk("R1 low strobe in reset", int'(ls), 0);
    chk("R1 high strobe in reset", int'(hs), 0);
    chk("R1 readback in reset", int'(rd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 scl after reset", int'(scl), 1);
    chk("R1 readback after reset", int'(rd), 0);

    // R2 field layout, upper bits dropped
    wr(32'hFFF3_5A7C);
    chk("R2 readback decode", int'(rd), int'(32'h0003_5A7C));
    // R3 clamp and boundary
    wr(32'h0007_0102);
    chk("R3 clamp readback", int'(rd), int'(32'h0005_FFFF));
    wr(32'h0006_0304);
    chk("R3 clamp ck=6 readback", int'(rd), int'(32'h0005_FFFF));
    wr(word(CKM, 3, 4));
    chk("R3 ck at max kept", int'(rd), int'(word(CKM, 3, 4)));

    // R9 enable start
    wr(word(0, 2, 1));
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk("R9 low strobe after enable", int'(ls), 1);
    chk("R9 scl low after enable", int'(scl), 0);

    // R4 R5 sweep
    for (int ck = 0; ck <= CKM; ck++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int hi = 0; hi < 4; hi++) begin
          wr(word(ck, hi, lo));
          chk("R2 sweep readback", int'(rd), int'(word(ck, hi, lo)));
          measure(0, 1'b0, '0, lo_m, hi_m);
          measure(0, 1'b0, '0, lo_m, hi_m);
          chk("R4 low length", lo_m, plen(lo, ck));
          chk("R5 high length", hi_m, plen(hi, ck));
        end
      end
    end

    // R3 clamped timing
    wr(32'h0007_0000);
    measure(0, 1'b0, '0, lo_m, hi_m);
    measure(0, 1'b0, '0, lo_m, hi_m);
    chk("R3 clamped low length", lo_m, plen(255, CKM));
    chk("R3 clamped high length", hi_m, plen(255, CKM));

    // R7 mid-period write
    wr(word(1, 1, 2));
    measure(0, 1'b0, '0, lo_m, hi_m);
    measure(0, 1'b1, word(2, 3, 4), lo_m, hi_m);
    chk("R7 old low length kept", lo_m, plen(2, 1));
    chk("R7 old high length kept", hi_m, plen(1, 1));
    chk("R7 readback updated", int'(rd), int'(word(2, 3, 4)));
    measure(0, 1'b0, '0, lo_m, hi_m);
    chk("R7 new low length", lo_m, plen(4, 2));
    chk("R7 new high length", hi_m, plen(3, 2));

    // R8 stretch
    wr(word(0, 2, 1));
    measure(0, 1'b0, '0, lo_m, hi_m);
    measure(6, 1'b0, '0, lo_m, hi_m);
    chk("R8 stretched low length", lo_m, plen(1, 0) + 6);
    chk("R8 high ignores stretch", hi_m, plen(2, 0));
    measure(0, 1'b0, '0, lo_m, hi_m);
    chk("R8 low after stretch", lo_m, plen(1, 0));

    // R6 strobe exclusivity and scl level over a period
    begin
      int both = 0;
      int bad_scl = 0;
      bit in_low = 1'b0;
      @(negedge clk);
      while (!ls) @(negedge clk);
      repeat (3 * (plen(1, 0) + plen(2, 0))) begin
        if (ls && hs) both++;
        if (ls) in_low = 1'b1;
        if (hs) in_low = 1'b0;
        if (scl !== !in_low) bad_scl++;
        @(negedge clk);
      end
      chk("R6 strobes never together", both, 0);
      chk("R6 scl follows phase", bad_scl, 0);
    end

    // R9 disable
    enable = 1'b0;
    begin
      int bad = 0;
      repeat (6) begin
        @(negedge clk);
        if (scl !== 1'b1 || ls !== 1'b0 || hs !== 1'b0) bad++;
      end
      chk("R9 idle while disabled", bad, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    chk("R9 restart low strobe", int'(ls), 1);
    measure(0, 1'b0, '0, lo_m, hi_m);
    chk("R9 low length after restart", lo_m, plen(1, 0));

    report();
  end
endmodule